// File: doc/BRIEF.md
# Biased Random Instruction Stream Generator

This block is a synthesizable stimulus source for differential testing of a RISC-V core against a reference model. It produces 32-bit instruction words without end. Each word begins as pseudo-random bits. The generator then pushes the word toward legal encodings in three steps, each gated by its own probability. A short multi-instruction template may be played instead of a single word. The opcode may be overwritten with a valid one. A field mutation may be applied that targets the architectural corner cases: the zero register, aliased registers, extreme immediates and real CSR addresses.

Words leave through a valid/ready handshake. A seed port restarts the pseudo-random source, so that a failing stream can be reproduced exactly. All random choices come from one 32-bit maximal-length LFSR. For each accepted word the LFSR makes three 32-step jumps. The first word of each jump carries the raw instruction bits, the second the gate bits, and the third the selection bits.

Top module: `instr_stream_gen`

## Requirements
- R1: While `rstN` is low, `outValid` is 0. It rises at the first rising edge after reset release. The first word is then generated from the state value 0x1D872B41.
- R2: While `outValid` is 1 and `outReady` is 0, the next cycle shows the same `outInstr`, and `outValid` stays 1 unless `seedLoad` is high. Generator state changes only on a cycle with `outValid` and `outReady` both high, or on a seed load.
- R3: A cycle with `seedLoad` high forces `outValid` to 0 in that cycle. It sets the LFSR state to `seedValue`, with the value 0 replaced by 0x1D872B41. It also abandons any sequence in progress.
- R4: The LFSR step is s' = {s[30:0], s[31]^s[21]^s[1]^s[0]}, and J(s) denotes 32 such steps. For the current state S: W0 = S, W1 = J(W0) and W2 = J(W1). An accepted word sets the state to J(W2). Unless a later rule changes it, a single word equals W0.
- R5: If a sequence is in progress, its next slot is emitted and no other rule applies. A sequence has exactly 4 slots, and after its 4th slot is accepted, generation resumes.
- R6: If no sequence is in progress and W1[9:0] < 10, template W2[0] starts with register A = W2[17:13] and register B = W2[22:18], and its slot 0 is emitted. Template 0 is: LUI A,0x10000; ADDI A,A,16; SW B,0(A); LW B,0(A). Template 1 is: ADDI A,x0,-1; ADD B,A,A; SUB B,B,A; BEQ A,B,+8.
- R7: In a single word with W1[19:10] < 1004, bits [6:0] are replaced by entry W2[4:1] of the opcode table. The table, by index 0 to 15, is 0x37,0x17,0x6F,0x67,0x63,0x03,0x23,0x13,0x33,0x0F,0x73,0x13,0x33,0x03,0x23,0x63.
- R8: In a single word with W1[29:20] < 205, rule W2[7:5] is applied after the opcode step. The fields are rd [11:7], rs1 [19:15] and rs2 [24:20]. Rule 0 sets rd to 0. Rule 1 copies rs1 into rd. Rule 2 copies rs2 into rd. Rule 3 copies rs2 into rs1. Rule 4 copies rs2 into both rd and rs1.
- R9: Rules 5 and 7 write bits [31:20] from an immediate table indexed by W2[10:8]. The table holds 0x800, 0xFFF, 0x000, 0x001, 0x7FF, 0x800, 0x7FF, 0x000. Rule 6 writes bits [31:20] with one of the CSR addresses 0x300, 0x305, 0x341, 0x342, indexed by W2[12:11].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load `seedValue` into the LFSR and abandon any sequence |
| seedValue | input | 32 | Seed for the LFSR; 0 is replaced by a nonzero constant |
| outValid | output | 1 | An instruction word is offered |
| outReady | input | 1 | Consumer accepts the offered word |
| outInstr | output | 32 | Offered instruction word |

## Verification
Several seeds, including zero, are each run against a consumer that is always ready, ready on random cycles, ready on alternate cycles, or only rarely ready. Full-rate acceptance checks the state advance from word to word. Stalled patterns show whether the offered word and the sequence position hold still under back-pressure. A bench model predicts every word and tags it with the rule that produced it: raw, opcode, register mutation, immediate/CSR mutation, sequence start or sequence step. A mismatch therefore points to one stage. A seed load issued right after a sequence start checks that the unfinished template is dropped, and the zero seed is checked against the stream that follows reset.

// File: rtl/isg_pkg.sv
package isg_pkg;

  localparam int INSTR_W   = 32;
  localparam int SEQ_LEN   = 4;
  localparam int SEQ_IDX_W = $clog2(SEQ_LEN);
  localparam int GATE_W    = 10;
  localparam int REG_W     = 5;
  localparam logic [INSTR_W-1:0] SEED_FALLBACK = 32'h1D87_2B41;

  // Field positions of the base instruction formats
  localparam int RD_LSB  = 7;
  localparam int RS1_LSB = 15;
  localparam int RS2_LSB = 20;
  localparam int IMM_LSB = 20;
  localparam int IMM_W   = 12;
  localparam int OPC_W   = 7;

  typedef enum logic [1:0] {SRC_KEEP, SRC_REG_A, SRC_REG_B} regSrc_e;

  typedef struct packed {
    logic [INSTR_W-1:0] base;
    regSrc_e            rdSrc;
    regSrc_e            rs1Src;
    regSrc_e            rs2Src;
  } seqSlot_t;

  typedef enum logic [2:0] {
    MUT_RD_ZERO, MUT_RD_RS1, MUT_RD_RS2, MUT_RS1_RS2,
    MUT_ALL_RS2, MUT_IMM_A, MUT_CSR, MUT_IMM_B
  } mutRule_e;

  // Strobes from control to the random source
  typedef struct packed {
    logic advance;
    logic load;
  } rngCtl_t;

  // Strobes from control to the word assembler
  typedef struct packed {
    logic playSeq;
    logic injectOpc;
    logic mutate;
  } asmCtl_t;

  function automatic logic [INSTR_W-1:0] lfsrStep(input logic [INSTR_W-1:0] s);
    return {s[INSTR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [INSTR_W-1:0] lfsrJump(input logic [INSTR_W-1:0] s);
    logic [INSTR_W-1:0] t;
    t = s;
    for (int i = 0; i < INSTR_W; i++) t = lfsrStep(t);
    return t;
  endfunction

  function automatic logic [OPC_W-1:0] opcodeAt(input logic [3:0] idx);
    logic [OPC_W-1:0] r;
    case (idx)
      4'd0:  r = 7'h37;
      4'd1:  r = 7'h17;
      4'd2:  r = 7'h6F;
      4'd3:  r = 7'h67;
      4'd4:  r = 7'h63;
      4'd5:  r = 7'h03;
      4'd6:  r = 7'h23;
      4'd7:  r = 7'h13;
      4'd8:  r = 7'h33;
      4'd9:  r = 7'h0F;
      4'd10: r = 7'h73;
      4'd11: r = 7'h13;
      4'd12: r = 7'h33;
      4'd13: r = 7'h03;
      4'd14: r = 7'h23;
      default: r = 7'h63;
    endcase
    return r;
  endfunction

  function automatic logic [IMM_W-1:0] immAt(input logic [2:0] idx);
    logic [IMM_W-1:0] r;
    case (idx)
      3'd0: r = 12'h800;
      3'd1: r = 12'hFFF;
      3'd2: r = 12'h000;
      3'd3: r = 12'h001;
      3'd4: r = 12'h7FF;
      3'd5: r = 12'h800;
      3'd6: r = 12'h7FF;
      default: r = 12'h000;
    endcase
    return r;
  endfunction

  function automatic logic [IMM_W-1:0] csrAt(input logic [1:0] idx);
    logic [IMM_W-1:0] r;
    case (idx)
      2'd0: r = 12'h300;
      2'd1: r = 12'h305;
      2'd2: r = 12'h341;
      default: r = 12'h342;
    endcase
    return r;
  endfunction

  function automatic seqSlot_t seqSlotAt(input logic id, input logic [SEQ_IDX_W-1:0] idx);
    seqSlot_t r;
    case ({id, idx})
      3'd0: r = '{32'h1000_0037, SRC_REG_A, SRC_KEEP,  SRC_KEEP};
      3'd1: r = '{32'h0100_0013, SRC_REG_A, SRC_REG_A, SRC_KEEP};
      3'd2: r = '{32'h0000_2023, SRC_KEEP,  SRC_REG_A, SRC_REG_B};
      3'd3: r = '{32'h0000_2003, SRC_REG_B, SRC_REG_A, SRC_KEEP};
      3'd4: r = '{32'hFFF0_0013, SRC_REG_A, SRC_KEEP,  SRC_KEEP};
      3'd5: r = '{32'h0000_0033, SRC_REG_B, SRC_REG_A, SRC_REG_A};
      3'd6: r = '{32'h4000_0033, SRC_REG_B, SRC_REG_B, SRC_REG_A};
      default: r = '{32'h0000_0463, SRC_KEEP, SRC_REG_A, SRC_REG_B};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/isg_rng.sv
module isg_rng
  import isg_pkg::*;
#(
  parameter logic [INSTR_W-1:0] RESET_SEED = SEED_FALLBACK
) (
  input  logic               clk,
  input  logic               rstN,
  input  rngCtl_t            ctl,
  input  logic [INSTR_W-1:0] seedValue,
  output logic [INSTR_W-1:0] rawWord,
  output logic [29:0]        gateBits,
  output logic [22:0]        pickBits
);

  logic [INSTR_W-1:0] state;
  logic [INSTR_W-1:0] gateWord;
  logic [INSTR_W-1:0] pickWord;

  always_comb begin
    gateWord = lfsrJump(state);
    pickWord = lfsrJump(gateWord);
  end

  assign rawWord  = state;
  assign gateBits = gateWord[29:0];
  assign pickBits = pickWord[22:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= RESET_SEED;
    end else if (ctl.load) begin
      state <= (seedValue == '0) ? SEED_FALLBACK : seedValue;
    end else if (ctl.advance) begin
      state <= lfsrJump(pickWord);
    end
  end

  // R4: the all-zero lock-up state is never entered
  assert_state_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

  // R2: the random source only moves on an accepted word or a seed load
  assert_state_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.load) |=> $stable(state));

endmodule

// File: rtl/isg_ctrl.sv
module isg_ctrl
  import isg_pkg::*;
#(
  parameter int SEQ_GATE = 10,
  parameter int OPC_GATE = 1004,
  parameter int MUT_GATE = 205
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 seedLoad,
  input  logic                 outReady,
  input  logic [29:0]          gateBits,
  input  logic                 pickId,
  input  logic [2*REG_W-1:0]   pickRegs,
  output rngCtl_t              rngCtl,
  output asmCtl_t              asmCtl,
  output logic                 outValid,
  output logic                 selId,
  output logic [SEQ_IDX_W-1:0] selIdx,
  output logic [REG_W-1:0]     selA,
  output logic [REG_W-1:0]     selB
);

  localparam logic [GATE_W-1:0] SEQ_LIMIT = GATE_W'(SEQ_GATE);
  localparam logic [GATE_W-1:0] OPC_LIMIT = GATE_W'(OPC_GATE);
  localparam logic [GATE_W-1:0] MUT_LIMIT = GATE_W'(MUT_GATE);
  localparam logic [SEQ_IDX_W-1:0] LAST_IDX = SEQ_IDX_W'(SEQ_LEN - 1);

  logic                 started;
  logic                 seqActive;
  logic                 seqId;
  logic [SEQ_IDX_W-1:0] seqIdx;
  logic [REG_W-1:0]     regA;
  logic [REG_W-1:0]     regB;
  logic                 startSeq;
  logic                 accept;

  assign outValid = started && !seedLoad;
  assign accept   = outValid && outReady;

  assign startSeq = !seqActive && (gateBits[GATE_W-1:0] < SEQ_LIMIT);

  always_comb begin
    rngCtl.advance   = accept;
    rngCtl.load      = seedLoad;
    asmCtl.playSeq   = seqActive || startSeq;
    asmCtl.injectOpc = gateBits[2*GATE_W-1:GATE_W] < OPC_LIMIT;
    asmCtl.mutate    = gateBits[3*GATE_W-1:2*GATE_W] < MUT_LIMIT;
  end

  always_comb begin
    if (seqActive) begin
      selId  = seqId;
      selIdx = seqIdx;
      selA   = regA;
      selB   = regB;
    end else begin
      selId  = pickId;
      selIdx = '0;
      selA   = pickRegs[REG_W-1:0];
      selB   = pickRegs[2*REG_W-1:REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      started   <= 1'b0;
      seqActive <= 1'b0;
      seqId     <= 1'b0;
      seqIdx    <= '0;
      regA      <= '0;
      regB      <= '0;
    end else begin
      started <= 1'b1;
      if (seedLoad) begin
        seqActive <= 1'b0;
      end else if (accept) begin
        if (seqActive) begin
          if (seqIdx == LAST_IDX) seqActive <= 1'b0;
          seqIdx <= seqIdx + SEQ_IDX_W'(1);
        end else if (startSeq) begin
          seqActive <= 1'b1;
          seqIdx    <= SEQ_IDX_W'(1);
          seqId     <= pickId;
          regA      <= pickRegs[REG_W-1:0];
          regB      <= pickRegs[2*REG_W-1:REG_W];
        end
      end
    end
  end

  // R2: an offer withdrawn only through a seed load
  assert_valid_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid || seedLoad));

  // R3: a seed load drops any template in progress
  assert_seed_abort_R3: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> !seqActive);

  // R5: the last slot ends the template
  assert_seq_exhaust_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seqActive && accept && seqIdx == LAST_IDX) |=> !seqActive);

  // R5: an inner slot moves to the next slot
  assert_seq_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seqActive && accept && seqIdx != LAST_IDX)
      |=> (seqActive && seqIdx == $past(seqIdx) + SEQ_IDX_W'(1)));

  // R6: a started template continues at slot 1
  assert_seq_begin_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && startSeq) |=> (seqActive && seqIdx == SEQ_IDX_W'(1)));

endmodule

// File: rtl/isg_datapath.sv
module isg_datapath
  import isg_pkg::*;
(
  input  asmCtl_t              ctl,
  input  logic [INSTR_W-1:0]   rawWord,
  input  logic [11:0]          pickMut,
  input  logic                 seqId,
  input  logic [SEQ_IDX_W-1:0] seqIdx,
  input  logic [REG_W-1:0]     regA,
  input  logic [REG_W-1:0]     regB,
  output logic [INSTR_W-1:0]   instr
);

  localparam int NUM_REG_FIELDS = 3;

  seqSlot_t           slot;
  regSrc_e            fieldSrc [NUM_REG_FIELDS];
  logic [REG_W-1:0]   fieldVal [NUM_REG_FIELDS];
  logic [INSTR_W-1:0] seqWord;
  logic [INSTR_W-1:0] biased;
  logic [INSTR_W-1:0] mutated;
  mutRule_e           rule;

  assign slot        = seqSlotAt(seqId, seqIdx);
  assign fieldSrc[0] = slot.rdSrc;
  assign fieldSrc[1] = slot.rs1Src;
  assign fieldSrc[2] = slot.rs2Src;

  // One register-field chooser per template field
  for (genvar f = 0; f < NUM_REG_FIELDS; f++) begin : g_field
    assign fieldVal[f] = (fieldSrc[f] == SRC_REG_B) ? regB : regA;
  end

  always_comb begin
    seqWord = slot.base;
    if (fieldSrc[0] != SRC_KEEP) seqWord[RD_LSB  +: REG_W] = fieldVal[0];
    if (fieldSrc[1] != SRC_KEEP) seqWord[RS1_LSB +: REG_W] = fieldVal[1];
    if (fieldSrc[2] != SRC_KEEP) seqWord[RS2_LSB +: REG_W] = fieldVal[2];
  end

  assign rule = mutRule_e'(pickMut[6:4]);

  always_comb begin
    biased = rawWord;
    if (ctl.injectOpc) biased[OPC_W-1:0] = opcodeAt(pickMut[3:0]);
    mutated = biased;
    if (ctl.mutate) begin
      case (rule)
        MUT_RD_ZERO: mutated[RD_LSB +: REG_W]  = '0;
        MUT_RD_RS1:  mutated[RD_LSB +: REG_W]  = biased[RS1_LSB +: REG_W];
        MUT_RD_RS2:  mutated[RD_LSB +: REG_W]  = biased[RS2_LSB +: REG_W];
        MUT_RS1_RS2: mutated[RS1_LSB +: REG_W] = biased[RS2_LSB +: REG_W];
        MUT_ALL_RS2: begin
          mutated[RD_LSB  +: REG_W] = biased[RS2_LSB +: REG_W];
          mutated[RS1_LSB +: REG_W] = biased[RS2_LSB +: REG_W];
        end
        MUT_CSR:     mutated[IMM_LSB +: IMM_W] = csrAt(pickMut[11:10]);
        default:     mutated[IMM_LSB +: IMM_W] = immAt(pickMut[9:7]);
      endcase
    end
    instr = ctl.playSeq ? seqWord : mutated;
  end

endmodule

// File: rtl/instr_stream_gen.sv
module instr_stream_gen
  import isg_pkg::*;
#(
  parameter int SEQ_GATE = 10,
  parameter int OPC_GATE = 1004,
  parameter int MUT_GATE = 205,
  parameter logic [31:0] RESET_SEED = SEED_FALLBACK
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        seedLoad,
  input  logic [31:0] seedValue,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outInstr
);

  rngCtl_t              rngCtl;
  asmCtl_t              asmCtl;
  logic [INSTR_W-1:0]   rawWord;
  logic [29:0]          gateBits;
  logic [22:0]          pickBits;
  logic                 selId;
  logic [SEQ_IDX_W-1:0] selIdx;
  logic [REG_W-1:0]     selA;
  logic [REG_W-1:0]     selB;

  isg_rng #(.RESET_SEED(RESET_SEED)) u_rng (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (rngCtl),
    .seedValue (seedValue),
    .rawWord   (rawWord),
    .gateBits  (gateBits),
    .pickBits  (pickBits)
  );

  isg_ctrl #(
    .SEQ_GATE (SEQ_GATE),
    .OPC_GATE (OPC_GATE),
    .MUT_GATE (MUT_GATE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .seedLoad (seedLoad),
    .outReady (outReady),
    .gateBits (gateBits),
    .pickId   (pickBits[0]),
    .pickRegs (pickBits[22:13]),
    .rngCtl   (rngCtl),
    .asmCtl   (asmCtl),
    .outValid (outValid),
    .selId    (selId),
    .selIdx   (selIdx),
    .selA     (selA),
    .selB     (selB)
  );

  isg_datapath u_datapath (
    .ctl     (asmCtl),
    .rawWord (rawWord),
    .pickMut (pickBits[12:1]),
    .seqId   (selId),
    .seqIdx  (selIdx),
    .regA    (selA),
    .regB    (selB),
    .instr   (outInstr)
  );

  // R2: an offered word does not change while the consumer stalls
  assert_instr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outInstr));

endmodule

// File: tb/instr_stream_gen_bench.sv
module instr_stream_gen_bench;

  localparam logic [31:0] FALLBACK = 32'h1D87_2B41;

  logic        clk = 1'b0;
  logic        rstN;
  logic        seedLoad;
  logic [31:0] seedValue;
  logic        outValid;
  logic        outReady;
  logic [31:0] outInstr;

  always #5 clk = ~clk;

  instr_stream_gen u_instr_stream_gen (
    .clk       (clk),
    .rstN      (rstN),
    .seedLoad  (seedLoad),
    .seedValue (seedValue),
    .outValid  (outValid),
    .outReady  (outReady),
    .outInstr  (outInstr)
  );

  typedef struct packed {
    logic [31:0] instr;
    logic [2:0]  kind;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit monOn  = 0;
  bit finished = 0;
  int kindSeen [6];
  bit abortMark = 0;

  // ---------------- reference model built from the requirements ----------------
  logic [31:0] mState;
  bit          mActive;
  logic        mId;
  int          mIdx;
  logic [4:0]  mA, mB;

  function automatic logic [31:0] stepOnce(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] jump32(input logic [31:0] s);
    logic [31:0] t = s;
    for (int k = 0; k < 32; k++) t = stepOnce(t);
    return t;
  endfunction

  function automatic logic [6:0] opcTab(input int i);
    logic [6:0] tab [16] = '{7'h37, 7'h17, 7'h6F, 7'h67, 7'h63, 7'h03, 7'h23, 7'h13,
                             7'h33, 7'h0F, 7'h73, 7'h13, 7'h33, 7'h03, 7'h23, 7'h63};
    return tab[i];
  endfunction

  function automatic logic [11:0] immTab(input int i);
    logic [11:0] tab [8] = '{12'h800, 12'hFFF, 12'h000, 12'h001,
                             12'h7FF, 12'h800, 12'h7FF, 12'h000};
    return tab[i];
  endfunction

  function automatic logic [11:0] csrTab(input int i);
    logic [11:0] tab [4] = '{12'h300, 12'h305, 12'h341, 12'h342};
    return tab[i];
  endfunction

  function automatic logic [31:0] tmpl(input logic id, input int idx,
                                       input logic [4:0] a, input logic [4:0] b);
    logic [31:0] ra = {27'd0, a};
    logic [31:0] rb = {27'd0, b};
    if (!id) begin
      case (idx)
        0: return 32'h1000_0037 | (ra << 7);
        1: return 32'h0100_0013 | (ra << 7) | (ra << 15);
        2: return 32'h0000_2023 | (ra << 15) | (rb << 20);
        default: return 32'h0000_2003 | (rb << 7) | (ra << 15);
      endcase
    end else begin
      case (idx)
        0: return 32'hFFF0_0013 | (ra << 7);
        1: return 32'h0000_0033 | (rb << 7) | (ra << 15) | (ra << 20);
        2: return 32'h4000_0033 | (rb << 7) | (rb << 15) | (ra << 20);
        default: return 32'h0000_0463 | (ra << 15) | (rb << 20);
      endcase
    end
  endfunction

  task automatic modelSeed(input logic [31:0] s);
    mState  = (s == 32'd0) ? FALLBACK : s;
    mActive = 0;
    mIdx    = 0;
  endtask

  // kind: 0 raw, 1 opcode, 2 register mutation, 3 imm/csr mutation, 4 seq start, 5 seq step
  task automatic modelNext(output expItem_t it);
    logic [31:0] w0, w1, w2, w;
    logic [2:0]  kd;
    int          rule;
    w0 = mState;
    w1 = jump32(w0);
    w2 = jump32(w1);
    if (mActive) begin
      w  = tmpl(mId, mIdx, mA, mB);
      kd = 3'd5;
      if (mIdx == 3) mActive = 0;
      mIdx = mIdx + 1;
    end else if (w1[9:0] < 10'd10) begin
      mId = w2[0];
      mA  = w2[17:13];
      mB  = w2[22:18];
      w   = tmpl(mId, 0, mA, mB);
      mActive = 1;
      mIdx    = 1;
      kd      = 3'd4;
    end else begin
      w  = w0;
      kd = 3'd0;
      if (w1[19:10] < 10'd1004) begin
        w[6:0] = opcTab(int'(w2[4:1]));
        kd = 3'd1;
      end
      if (w1[29:20] < 10'd205) begin
        rule = int'(w2[7:5]);
        kd   = (rule <= 4) ? 3'd2 : 3'd3;
        case (rule)
          0: w[11:7]  = 5'd0;
          1: w[11:7]  = w[19:15];
          2: w[11:7]  = w[24:20];
          3: w[19:15] = w[24:20];
          4: begin w[11:7] = w[24:20]; w[19:15] = w[24:20]; end
          6: w[31:20] = csrTab(int'(w2[12:11]));
          default: w[31:20] = immTab(int'(w2[10:8]));
        endcase
      end
    end
    mState = jump32(w2);
    it.instr = w;
    it.kind  = kd;
  endtask

  function automatic string kindTag(input logic [2:0] k);
    case (k)
      3'd0: return "R4 raw word";
      3'd1: return "R7 opcode injection";
      3'd2: return "R8 register mutation";
      3'd3: return "R9 immediate/CSR mutation";
      3'd4: return "R6 sequence start";
      default: return "R5 sequence step";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  bit          holdPending = 0;
  logic [31:0] heldInstr;

  always @(negedge clk) begin
    if (monOn) begin
      if (holdPending) begin
        check(outInstr === heldInstr, "R2 word held under stall", outInstr, heldInstr);
        check(outValid === 1'b1 || seedLoad === 1'b1, "R2 valid held under stall",
              {31'd0, outValid}, 32'd1);
      end
      holdPending = outValid && !outReady;
      heldInstr   = outInstr;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 accept with nothing expected", outInstr, 32'd0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(outInstr === it.instr,
                abortMark ? "R3 stream after aborted sequence" : kindTag(it.kind),
                outInstr, it.instr);
          abortMark = 0;
        end
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic pushItems(input int n);
    expItem_t it;
    for (int i = 0; i < n; i++) begin
      modelNext(it);
      kindSeen[it.kind]++;
      expQ.push_back(it);
    end
  endtask

  task automatic pushUntilSeqStart(input int minCount);
    expItem_t it;
    int n = 0;
    forever begin
      modelNext(it);
      kindSeen[it.kind]++;
      expQ.push_back(it);
      n++;
      if ((n >= minCount && it.kind == 3'd4) || n > 20000) break;
    end
  endtask

  task automatic drain(input int mode);
    bit toggle = 0;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() == 0) begin
        outReady = 1'b0;
        break;
      end
      toggle = !toggle;
      case (mode)
        0: outReady = 1'b1;
        1: outReady = ($urandom % 2) == 0;
        2: outReady = toggle;
        default: outReady = ($urandom % 4) == 0;
      endcase
    end
  endtask

  task automatic loadSeed(input logic [31:0] s);
    @(posedge clk);
    #1;
    outReady  = 1'b0;
    seedLoad  = 1'b1;
    seedValue = s;
    @(negedge clk);
    check(outValid === 1'b0, "R3 valid low during seed load", {31'd0, outValid}, 32'd0);
    @(posedge clk);
    #1;
    seedLoad = 1'b0;
    modelSeed(s);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  logic [31:0] firstReset;

  initial begin
    rstN      = 1'b0;
    seedLoad  = 1'b0;
    seedValue = 32'd0;
    outReady  = 1'b0;
    for (int k = 0; k < 6; k++) kindSeen[k] = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid === 1'b0, "R1 valid low in reset", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;

    modelSeed(FALLBACK);
    pushItems(1200);
    firstReset = expQ[0].instr;

    @(negedge clk);
    check(outValid === 1'b1, "R1 valid after reset release", {31'd0, outValid}, 32'd1);
    check(outInstr === firstReset, "R1 first word after reset", outInstr, firstReset);
    monOn = 1;
    drain(0);

    // zero seed falls back to the reset constant
    loadSeed(32'd0);
    @(negedge clk);
    check(outInstr === firstReset, "R3 zero seed replaced", outInstr, firstReset);
    pushItems(300);
    drain(1);

    // stop right after a sequence start, then reseed mid-sequence
    loadSeed(32'hDEAD_BEEF);
    pushUntilSeqStart(200);
    drain(2);
    loadSeed(32'h1234_5678);
    abortMark = 1;
    pushItems(1500);
    drain(3);

    loadSeed(32'hA5A5_0001);
    pushItems(2000);
    drain(1);

    // every generation path was exercised by the compared stream
    check(kindSeen[0] > 0, "R4 raw words compared", kindSeen[0], 1);
    check(kindSeen[1] > 0, "R7 opcode words compared", kindSeen[1], 1);
    check(kindSeen[2] > 0, "R8 register mutations compared", kindSeen[2], 1);
    check(kindSeen[3] > 0, "R9 immediate/CSR mutations compared", kindSeen[3], 1);
    check(kindSeen[4] > 0, "R6 sequence starts compared", kindSeen[4], 1);
    check(kindSeen[5] > 0, "R5 sequence steps compared", kindSeen[5], 1);
    check(expQ.size() == 0, "R2 all expected words accepted", expQ.size(), 0);

    repeat (4) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule